// File: doc/BRIEF.md
# Floating-Point Compare Exception Flag Unit

This execution unit takes two IEEE-754 single-precision operands and reports which IEEE exception conditions a greater-than comparison of them would raise. It does not return the outcome of the comparison. It returns an 8-bit flag vector, zero-extended to 32 bits, for a destination register. The write-back is guarded: the least significant bit of a guard operand decides whether the destination is written. Any global status word stays untouched, because the unit drives no status output.

A comparison never rounds, overflows, underflows or divides. Only two conditions can arise. A NaN operand makes the comparison invalid. A denormal operand is flushed to zero before the comparison, and that flush is reported in its own flag. Any other operands, including infinities of either sign and signed zeros, give an all-zero vector. The result and its write strobe appear one clock after the issue strobe. A pipeline that has no guard ties the guard input to 1.

Top module: `fcx_cmp_flags`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result_o` becomes 0 and `wr_en_o` becomes 0 after that edge, whatever the other inputs carry.
- R2: If `issue_i` is 1 and `guard_i[0]` is 1 at a rising edge, `wr_en_o` is 1 for exactly the following cycle and `result_o` holds the flag vector of that issue.
- R3: If `issue_i` is 1 and `guard_i[0]` is 0, `wr_en_o` stays 0 and `result_o` keeps its previous value. Guard bits 31..1 have no effect.
- R4: An operand whose exponent field (bits 30..23) is all ones and whose mantissa (bits 22..0) is non-zero is a NaN. If either operand is a NaN, bit 4 (invalid, 0x10) is set.
- R5: An operand whose exponent field is zero and whose mantissa is non-zero is a denormal. If either operand is a denormal, bit 5 (flush-to-zero on input, 0x20) is set.
- R6: A denormal together with a NaN gives 0x30.
- R7: Normal finite values, equal values, infinities of any sign and signed zeros give 0x00.
- R8: Bits 31..6 and bits 3..0 of `result_o` are always 0. Bit 6 is output flush, bit 3 overflow, bit 2 underflow, bit 1 inexact and bit 0 divide-by-zero.
- R9: If `issue_i` is 0 at an edge, `wr_en_o` is 0 in the following cycle and `result_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | Operation issued this cycle |
| guard_i | input | 32 | Guard operand; bit 0 enables the write |
| opa_i | input | 32 | First operand (left of the greater-than) |
| opb_i | input | 32 | Second operand |
| result_o | output | 32 | Zero-extended exception flag vector |
| wr_en_o | output | 1 | Destination write enable |

## Verification
The hardest cases to reach are the flag-raising ones, and the denormal-plus-NaN pair above all. Uniformly random 32-bit words almost never have a zero exponent with a non-zero mantissa, so they rarely produce a denormal. The bench therefore builds each operand from a randomly chosen class: normal, denormal, NaN, infinity or signed zero. A random mantissa and sign are laid over the chosen class, so both operand slots see every pairing, including the mixed 0x30 case. The random guard words have their upper bits set while bit 0 is clear, and issue gaps are mixed into the stream. Together these show that a blocked or idle cycle leaves the held result unchanged.

// File: rtl/fcx_pkg.sv
// Package: shared widths, flag bit positions and the per-operand class type.
// Assumes IEEE-754 binary32 layout: sign at MSB, then exponent, then mantissa.
package fcx_pkg;
    parameter int FP_W   = 32;
    parameter int EXP_W  = 8;
    parameter int MAN_W  = 23;
    parameter int FLAG_W = 8;

    // Flag bit positions inside the result vector
    localparam int BIT_DBZ = 0;
    localparam int BIT_INX = 1;
    localparam int BIT_UNF = 2;
    localparam int BIT_OVF = 3;
    localparam int BIT_INV = 4;
    localparam int BIT_IFZ = 5;
    localparam int BIT_OFZ = 6;

    typedef struct packed {
        logic is_nan;
        logic is_denorm;
    } op_class_t;
endpackage

// File: rtl/fcx_operand_class.sv
// Operand classifier: flags one binary32 word as NaN or denormal.
// Assumes the word follows the layout in fcx_pkg; zeros and infinities are neither class.
module fcx_operand_class
    import fcx_pkg::*;
#(
    parameter int W  = FP_W,
    parameter int EW = EXP_W,
    parameter int MW = MAN_W
) (
    input  logic [W-1:0] word_i,
    output op_class_t    class_o
);
    localparam int EXP_LO = MW;
    localparam int EXP_HI = MW + EW - 1;

    logic [EW-1:0] exp_f;
    logic [MW-1:0] man_f;
    logic          exp_max;
    logic          exp_min;
    logic          man_nz;

    // Split the word into its fields and decode the class
    always_comb begin
        exp_f   = word_i[EXP_HI:EXP_LO];
        man_f   = word_i[MW-1:0];
        exp_max = &exp_f;
        exp_min = ~|exp_f;
        man_nz  = |man_f;
        class_o.is_nan    = exp_max & man_nz;
        class_o.is_denorm = exp_min & man_nz;
    end

    // R4/R5: the two classes are exclusive for any word
    always_comb begin
        a_r5_class_exclusive: assert (!(class_o.is_nan && class_o.is_denorm))
            else $error("operand classified both NaN and denormal");
    end
endmodule

// File: rtl/fcx_flag_merge.sv
// Flag combiner: folds the classes of N operands into the exception vector.
// Assumes a compare can only raise invalid and input-flush; other bits stay 0.
module fcx_flag_merge
    import fcx_pkg::*;
#(
    parameter int N_OPS = 2,
    parameter int FW    = FLAG_W
) (
    input  op_class_t [N_OPS-1:0] class_i,
    output logic      [FW-1:0]    flags_o
);
    logic any_nan;
    logic any_den;

    // OR-reduce the per-operand classes and place them at their bit positions
    always_comb begin
        any_nan = 1'b0;
        any_den = 1'b0;
        for (int i = 0; i < N_OPS; i++) begin
            any_nan = any_nan | class_i[i].is_nan;
            any_den = any_den | class_i[i].is_denorm;
        end
        flags_o          = '0;
        flags_o[BIT_INV] = any_nan;
        flags_o[BIT_IFZ] = any_den;
    end
endmodule

// File: rtl/fcx_cmp_flags.sv
// Top: exception-flag unit for a floating-point greater-than compare.
// Classifies both operands, merges flags, registers the guarded write-back.
// Assumes issue_i is a one-cycle strobe per operation; synchronous active-low reset.
module fcx_cmp_flags
    import fcx_pkg::*;
#(
    parameter int N_OPS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic [FP_W-1:0]  guard_i,
    input  logic [FP_W-1:0]  opa_i,
    input  logic [FP_W-1:0]  opb_i,
    output logic [FP_W-1:0]  result_o,
    output logic             wr_en_o
);
    localparam int PAD_W = FP_W - FLAG_W;

    logic      [N_OPS-1:0][FP_W-1:0] ops;
    op_class_t [N_OPS-1:0]           cls;
    logic      [FLAG_W-1:0]          flags;
    logic                            commit;
    logic      [FP_W-1:0]            res_q;
    logic                            we_q;

    // Gather operands into an indexed array
    always_comb begin
        ops[0] = opa_i;
        ops[1] = opb_i;
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_OPS; gi++) begin : g_class
            fcx_operand_class u_class (
                .word_i (ops[gi]),
                .class_o(cls[gi])
            );
        end
    endgenerate

    fcx_flag_merge #(.N_OPS(N_OPS), .FW(FLAG_W)) u_merge (
        .class_i(cls),
        .flags_o(flags)
    );

    // Write happens only when issued with guard LSB set
    always_comb commit = issue_i & guard_i[0];

    // Result and write-enable register, one cycle latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            we_q  <= 1'b0;
        end else begin
            we_q <= commit;
            if (commit) res_q <= {{PAD_W{1'b0}}, flags};
        end
    end

    assign result_o = res_q;
    assign wr_en_o  = we_q;

    // R2: a guarded issue produces a write in the next cycle
    a_r2_write_follows_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && guard_i[0]) |=> wr_en_o);
    // R3: a false guard blocks the write and keeps the result
    a_r3_guard_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !guard_i[0]) |=> (!wr_en_o && $stable(result_o)));
    // R9: idle cycles leave the destination alone
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> (!wr_en_o && $stable(result_o)));
    // R4: a NaN operand on a guarded issue raises invalid
    a_r4_nan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (cls[0].is_nan || cls[1].is_nan)) |=> result_o[BIT_INV]);
    // R8: no bit outside invalid and input-flush is ever set
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (result_o & ~(32'h1 << BIT_INV | 32'h1 << BIT_IFZ)) == '0);
endmodule

// File: tb/tb_fcx_cmp_flags.sv
// Bench: directed corners plus class-mixed random operands, checked against a model.
module tb_fcx_cmp_flags;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [31:0] guard_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [31:0] result_o;
    logic        wr_en_o;

    int n_checks = 0;
    int n_err    = 0;
    logic [31:0] model_res = '0;

    fcx_cmp_flags dut (.*);

    always #10 clk = ~clk;  // 50 MHz

    function automatic logic is_nan(input logic [31:0] w);
        return (w[30:23] == 8'hFF) && (w[22:0] != 0);
    endfunction
    function automatic logic is_den(input logic [31:0] w);
        return (w[30:23] == 8'h00) && (w[22:0] != 0);
    endfunction
    function automatic logic [31:0] exp_flags(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] f = '0;
        if (is_nan(a) || is_nan(b)) f[4] = 1'b1;
        if (is_den(a) || is_den(b)) f[5] = 1'b1;
        return f;
    endfunction
    function automatic logic [31:0] gen_op(input int kind);
        logic [31:0] r = $urandom;
        case (kind)
            0: begin r[30:23] = 8'd1 + 8'($urandom_range(253)); end
            1: begin r[30:23] = 8'h00; if (r[22:0] == 0) r[0] = 1'b1; end
            2: begin r[30:23] = 8'hFF; if (r[22:0] == 0) r[22] = 1'b1; end
            3: begin r[30:0] = 31'h7F800000; end
            default: begin r[30:0] = '0; end
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at negedge, check at the next negedge (one register on the path)
    task automatic run_op(input string req, input logic iss, input logic [31:0] g,
                          input logic [31:0] a, input logic [31:0] b);
        logic wr = iss & g[0];
        issue_i = iss; guard_i = g; opa_i = a; opb_i = b;
        if (wr) model_res = exp_flags(a, b);
        @(negedge clk);
        check({req, " wr_en"}, {31'b0, wr_en_o}, {31'b0, wr});
        check({req, " result"}, result_o, model_res);
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R1: reset with garbage inputs pending
        issue_i = 1'b1; guard_i = 32'h1; opa_i = 32'hFFFFFFFF; opb_i = 32'h00400000;
        repeat (3) @(negedge clk);
        check("R1 result", result_o, 32'h0);
        check("R1 wr_en", {31'b0, wr_en_o}, 32'h0);
        rst_n = 1'b1;
        issue_i = 1'b0;
        run_op("R9 idle after reset", 1'b0, 32'h1, 32'hFFFFFFFF, 32'h0);
        run_op("R7 3.0 vs 0.0", 1'b1, 32'h1, 32'h40400000, 32'h0);
        run_op("R7 equal", 1'b1, 32'h1, 32'h40400000, 32'h40400000);
        run_op("R4 qnan", 1'b1, 32'h1, 32'h40400000, 32'hFFFFFFFF);
        run_op("R3 guard off", 1'b1, 32'h0, 32'h3F800000, 32'h40400000);
        run_op("R3 upper guard bits", 1'b1, 32'hFFFFFFFE, 32'h00000001, 32'h7FC00000);
        run_op("R2 guard on", 1'b1, 32'h1, 32'h3F800000, 32'h40400000);
        run_op("R7 +inf vs -inf", 1'b1, 32'h1, 32'h7F800000, 32'hFF800000);
        run_op("R7 inf vs itself", 1'b1, 32'h1, 32'h7F800000, 32'h7F800000);
        run_op("R5 denorm", 1'b1, 32'h1, 32'h3F800000, 32'h00400000);
        run_op("R9 idle holds", 1'b0, 32'h1, 32'h7F800001, 32'h0);
        run_op("R6 denorm+nan", 1'b1, 32'h1, 32'h80000001, 32'h7F800001);
        run_op("R7 signed zeros", 1'b1, 32'h1, 32'h80000000, 32'h00000000);
        run_op("R5 max denorm", 1'b1, 32'h1, 32'h007FFFFF, 32'h0);
        // Random: class-mixed operands, random guard, occasional idle
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] a = gen_op($urandom_range(4));
            logic [31:0] b = gen_op($urandom_range(4));
            logic [31:0] g = $urandom;
            logic        iss = ($urandom_range(7) != 0);
            run_op("R2/R3/R4/R5/R6/R8/R9 random", iss, g, a, b);
            check("R8 reserved", result_o & ~32'h30, 32'h0);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_err++; n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule